// File: doc/BRIEF.md
# Video Controller Two-Word Command Port

This block is the host-side control port of a video display controller. The host writes 16-bit control words to it. Each word is one of two things. It can be a register write, which the block forwards as a one-cycle strobe carrying an index and a data byte. Or it can be half of a two-word sequence that sets up a 17-bit video memory address and a 6-bit access code.

Address and code changes are collected in shadow latches and do not reach the live address and code outputs while the sequence is incomplete. The live registers take the latch contents at the moment the pending state ends. The pending state can end in four ways:

- the second control word arrives;
- any data port write;
- any data port read;
- a control port read.

When the second word leaves code bit 5 set, the block raises a one-cycle DMA start request. Control reads return a status word that combines open-bus bits, a FIFO-empty flag and status bits supplied from outside.

All outputs are registered. An input accepted at a clock edge is visible on the outputs just after that edge. At most one of the host strobes is expected in any cycle. If a control write coincides with another access, the control write is the one acted upon.

Top module: `vcmd_port`

## Requirements
- R1: Synchronous reset clears the pending flag, both shadow latches, the live address, the live code, the register strobe, the DMA start request and the read-flag clear strobe.
- R2: While `dma_busy` is high, a control word has no effect on the pending flag, the latches or any output.
- R3: A control word with bits 15:14 = 2'b10, written while not pending, produces `reg_stb` for one cycle. `reg_idx` carries word bits 12:8 and `reg_data` carries word bits 7:0. The pending flag stays clear.
- R4: The strobe in R3 is given only when the index is below NUM_REGS (24) with `mode5` high, or below LEGACY_REGS (11) with `mode5` low.
- R5: Any other control word written while not pending sets `pending`. It loads latch address bits 13:0 from word bits 13:0 and latch code bits 1:0 from word bits 15:14. The live address and code do not change while pending.
- R6: A control word written while pending clears `pending` and loads latch address bits 16:14 from word bits 2:0. It merges word bits 7:2 into code bits 5:0, keeping code bits 1:0 from the latch. The merged latch is copied to the live outputs at the same edge, and `rdflag_clr` pulses.
- R7: If `dma_enable` is low during the second word, code bit 5 keeps its latched value.
- R8: A data write, data read or control read while pending clears `pending` and copies the latches to the live outputs. `rdflag_clr` pulses for the two data accesses only.
- R9: `dma_start` pulses for one cycle after a second word that leaves live code bit 5 set, and stays low otherwise.
- R10: A control read registers {open_bus[15:10], fifo_empty, stat_lo[8:0]} onto `ctrl_rdata`.
- R11: A first word keeps latch address bits 16:14 and code bits 5:2 from earlier sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word |
| ctrl_rd | input | 1 | Control (status) read strobe |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| dma_busy | input | 1 | A DMA transfer is running |
| dma_enable | input | 1 | Mode bit allowing code bit 5 to change |
| mode5 | input | 1 | Extended register set mode |
| open_bus | input | 16 | External open-bus value |
| fifo_empty | input | 1 | Write FIFO is empty |
| stat_lo | input | 9 | Low status bits from elsewhere |
| ctrl_rdata | output | 16 | Registered status word |
| reg_stb | output | 1 | Register write strobe |
| reg_idx | output | 5 | Register index |
| reg_data | output | 8 | Register data |
| pending | output | 1 | Waiting for second word |
| vram_addr | output | 17 | Live address |
| access_code | output | 6 | Live access code |
| rdflag_clr | output | 1 | Clear read-fetched and read-pending flags |
| dma_start | output | 1 | DMA start request |

## Verification
The hardest case to reach is a second word that carries no code bit 5 while `dma_enable` is low and the latched code bit 5 is already set. In that case, only the value carried over from an earlier sequence reveals whether bit 5 was protected.

The stimulus builds this case in steps:

1. An earlier sequence with DMA enabled sets bit 5.
2. DMA is then disabled.
3. A fresh sequence is sent whose second word leaves bit 7 clear.

The expected result is that live code bit 5 stays set and `dma_start` fires again. The same chain also shows that the upper address bits survive the first word of the next sequence.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 17;
  localparam int ADDR_LO_W = 14;
  localparam int ADDR_HI_W = ADDR_W - ADDR_LO_W;
  localparam int CODE_W    = 6;
  localparam int IDX_W     = 5;
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic              is_reg;
    logic              reg_ok;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] nxt_addr;
    logic [CODE_W-1:0] nxt_code;
  } cmd_t;
endpackage

// File: rtl/vcp_decode.sv
module vcp_decode
  import vcp_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int LEGACY_REGS = 11
) (
  input  logic [WORD_W-1:0] word,
  input  logic              pending,
  input  logic              dma_enable,
  input  logic              mode5,
  input  logic [ADDR_W-1:0] latch_addr,
  input  logic [CODE_W-1:0] latch_code,
  output cmd_t              cmd
);
  localparam logic [CODE_W-1:0] KEEP_DMA   = CODE_W'(3);
  localparam logic [CODE_W-1:0] KEEP_NODMA = CODE_W'(3) | (CODE_W'(1) << (CODE_W-1));

  logic [CODE_W-1:0] keep;
  logic [CODE_W-1:0] shifted;
  int unsigned       limit;

  always_comb begin
    keep    = dma_enable ? KEEP_DMA : KEEP_NODMA;
    shifted = word[CODE_W+1:2];
    limit   = mode5 ? NUM_REGS : LEGACY_REGS;
    cmd.is_reg = (word[WORD_W-1:WORD_W-2] == 2'b10);
    cmd.idx    = word[IDX_W+7:8];
    cmd.data   = word[DATA_W-1:0];
    cmd.reg_ok = (int'(cmd.idx) < limit);
    if (pending) begin
      cmd.nxt_addr = {word[ADDR_HI_W-1:0], latch_addr[ADDR_LO_W-1:0]};
      cmd.nxt_code = (latch_code & keep) | (shifted & ~keep);
    end else begin
      cmd.nxt_addr = {latch_addr[ADDR_W-1:ADDR_LO_W], word[ADDR_LO_W-1:0]};
      cmd.nxt_code = {latch_code[CODE_W-1:2], word[WORD_W-1:WORD_W-2]};
    end
  end
endmodule

// File: rtl/vcp_latch_bank.sv
module vcp_latch_bank
  import vcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              dma_busy,
  input  logic              dma_enable,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              ctrl_rd,
  input  cmd_t              cmd,
  output logic              pending,
  output logic [ADDR_W-1:0] latch_addr,
  output logic [CODE_W-1:0] latch_code,
  output logic [ADDR_W-1:0] live_addr,
  output logic [CODE_W-1:0] live_code,
  output logic              dma_start,
  output logic              rdflag_clr
);
  logic accept;
  logic other;

  assign accept = ctrl_wr & ~dma_busy;
  assign other  = data_wr | data_rd | ctrl_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      latch_addr <= '0;
      latch_code <= '0;
      live_addr  <= '0;
      live_code  <= '0;
      dma_start  <= 1'b0;
      rdflag_clr <= 1'b0;
    end else begin
      dma_start  <= 1'b0;
      rdflag_clr <= 1'b0;
      if (accept) begin
        latch_addr <= cmd.nxt_addr;
        latch_code <= cmd.nxt_code;
        if (pending) begin
          pending    <= 1'b0;
          live_addr  <= cmd.nxt_addr;
          live_code  <= cmd.nxt_code;
          dma_start  <= cmd.nxt_code[CODE_W-1];
          rdflag_clr <= 1'b1;
        end else begin
          pending <= ~cmd.is_reg;
        end
      end else if (other && pending) begin
        pending    <= 1'b0;
        live_addr  <= latch_addr;
        live_code  <= latch_code;
        rdflag_clr <= data_wr | data_rd;
      end
    end
  end

  p_dma_lock_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && dma_busy && !other) |=>
      ($stable(pending) && $stable(latch_addr) && $stable(latch_code)));

  p_reg_nopend_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !pending && cmd.is_reg) |=> !pending);

  p_live_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$fell(pending) |-> ($stable(live_addr) && $stable(live_code)));

  p_code5_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && pending && !dma_enable) |=>
      (live_code[CODE_W-1] == $past(latch_code[CODE_W-1])));

  p_pend_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (pending && !ctrl_wr && other) |=>
      (!pending && live_addr == $past(latch_addr) && live_code == $past(latch_code)));

  p_start_code_r9: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> (live_code[CODE_W-1] && !pending));
endmodule

// File: rtl/vcp_regwr.sv
module vcp_regwr
  import vcp_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int LEGACY_REGS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              dma_busy,
  input  logic              pending,
  input  logic              mode5,
  input  cmd_t              cmd,
  output logic              reg_stb,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_stb  <= 1'b0;
      reg_idx  <= '0;
      reg_data <= '0;
    end else begin
      reg_stb <= ctrl_wr & ~dma_busy & ~pending & cmd.is_reg & cmd.reg_ok;
      if (ctrl_wr && !dma_busy && !pending && cmd.is_reg) begin
        reg_idx  <= cmd.idx;
        reg_data <= cmd.data;
      end
    end
  end

  p_idx_limit_r4: assert property (@(posedge clk) disable iff (rst)
    reg_stb |-> (int'(reg_idx) < ($past(mode5) ? NUM_REGS : LEGACY_REGS)));
endmodule

// File: rtl/vcp_status.sv
module vcp_status
  import vcp_pkg::*;
#(
  parameter int LOW_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_rd,
  input  logic [WORD_W-1:0] open_bus,
  input  logic              fifo_empty,
  input  logic [LOW_W-1:0]  stat_lo,
  output logic [WORD_W-1:0] ctrl_rdata
);
  always_ff @(posedge clk) begin
    if (rst) ctrl_rdata <= '0;
    else if (ctrl_rd)
      ctrl_rdata <= {open_bus[WORD_W-1:LOW_W+1], fifo_empty, stat_lo};
  end

  p_fifo_bit_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> (ctrl_rdata[LOW_W] == $past(fifo_empty)));
endmodule

// File: rtl/vcmd_port.sv
module vcmd_port
  import vcp_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int LEGACY_REGS = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_wr,
  input  logic [15:0] ctrl_wdata,
  input  logic        ctrl_rd,
  input  logic        data_wr,
  input  logic        data_rd,
  input  logic        dma_busy,
  input  logic        dma_enable,
  input  logic        mode5,
  input  logic [15:0] open_bus,
  input  logic        fifo_empty,
  input  logic [8:0]  stat_lo,
  output logic [15:0] ctrl_rdata,
  output logic        reg_stb,
  output logic [4:0]  reg_idx,
  output logic [7:0]  reg_data,
  output logic        pending,
  output logic [16:0] vram_addr,
  output logic [5:0]  access_code,
  output logic        rdflag_clr,
  output logic        dma_start
);
  cmd_t              cmd;
  logic [ADDR_W-1:0] latch_addr;
  logic [CODE_W-1:0] latch_code;

  vcp_decode #(.NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)) u_dec (
    .word(ctrl_wdata), .pending(pending), .dma_enable(dma_enable), .mode5(mode5),
    .latch_addr(latch_addr), .latch_code(latch_code), .cmd(cmd));

  vcp_latch_bank u_lat (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .dma_busy(dma_busy),
    .dma_enable(dma_enable), .data_wr(data_wr), .data_rd(data_rd),
    .ctrl_rd(ctrl_rd), .cmd(cmd), .pending(pending),
    .latch_addr(latch_addr), .latch_code(latch_code),
    .live_addr(vram_addr), .live_code(access_code),
    .dma_start(dma_start), .rdflag_clr(rdflag_clr));

  vcp_regwr #(.NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)) u_reg (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .dma_busy(dma_busy),
    .pending(pending), .mode5(mode5), .cmd(cmd),
    .reg_stb(reg_stb), .reg_idx(reg_idx), .reg_data(reg_data));

  vcp_status #(.LOW_W(9)) u_sts (
    .clk(clk), .rst(rst), .ctrl_rd(ctrl_rd), .open_bus(open_bus),
    .fifo_empty(fifo_empty), .stat_lo(stat_lo), .ctrl_rdata(ctrl_rdata));
endmodule

// File: tb/vcmd_port_test.sv
module vcmd_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr = 0, ctrl_rd = 0, data_wr = 0, data_rd = 0;
  logic [15:0] ctrl_wdata = '0;
  logic        dma_busy = 0, dma_enable = 1, mode5 = 1, fifo_empty = 1;
  logic [15:0] open_bus = 16'hA400;
  logic [8:0]  stat_lo = 9'h155;
  logic [15:0] ctrl_rdata;
  logic        reg_stb, pending, rdflag_clr, dma_start;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_data;
  logic [16:0] vram_addr;
  logic [5:0]  access_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vcmd_port uut (.*);

  typedef struct {
    logic        pend;
    logic [16:0] la;
    logic [5:0]  lc;
    logic        stb;
    logic [4:0]  idx;
    logic [7:0]  dat;
    logic        ds;
    logic        rc;
    logic        rdv;
    logic [15:0] rd;
    string       req;
  } exp_t;

  exp_t sbq[$];

  logic        m_pend = 0;
  logic [16:0] m_laddr = '0, m_live_a = '0;
  logic [5:0]  m_lcode = '0, m_live_c = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.req, "pending", 32'(pending), 32'(e.pend));
      chk(e.req, "vram_addr", 32'(vram_addr), 32'(e.la));
      chk(e.req, "access_code", 32'(access_code), 32'(e.lc));
      chk("R3/R4", "reg_stb", 32'(reg_stb), 32'(e.stb));
      if (e.stb) begin
        chk("R3", "reg_idx", 32'(reg_idx), 32'(e.idx));
        chk("R3", "reg_data", 32'(reg_data), 32'(e.dat));
      end
      chk("R9", "dma_start", 32'(dma_start), 32'(e.ds));
      chk("R8", "rdflag_clr", 32'(rdflag_clr), 32'(e.rc));
      if (e.rdv) chk("R10", "ctrl_rdata", 32'(ctrl_rdata), 32'(e.rd));
    end
  end

  task automatic step(input logic cw, input logic [15:0] w, input logic cr,
                      input logic dw, input logic dr, input string req);
    exp_t e;
    logic [5:0] keep;
    e.stb = 0; e.ds = 0; e.rc = 0; e.idx = '0; e.dat = '0;
    e.rdv = cr; e.rd = {open_bus[15:10], fifo_empty, stat_lo};
    if (cw && !dma_busy) begin
      if (m_pend) begin
        keep = dma_enable ? 6'h03 : 6'h23;
        m_laddr[16:14] = w[2:0];
        m_lcode = (m_lcode & keep) | (w[7:2] & ~keep);
        m_pend = 0; m_live_a = m_laddr; m_live_c = m_lcode;
        e.ds = m_lcode[5]; e.rc = 1;
      end else begin
        m_laddr[13:0] = w[13:0];
        m_lcode[1:0]  = w[15:14];
        if (w[15:14] == 2'b10) begin
          e.stb = (int'(w[12:8]) < (mode5 ? 24 : 11));
          e.idx = w[12:8]; e.dat = w[7:0];
        end else m_pend = 1;
      end
    end else if ((cr || dw || dr) && m_pend) begin
      m_pend = 0; m_live_a = m_laddr; m_live_c = m_lcode;
      e.rc = dw | dr;
    end
    e.pend = m_pend; e.la = m_live_a; e.lc = m_live_c; e.req = req;
    sbq.push_back(e);
    ctrl_wr = cw; ctrl_wdata = w; ctrl_rd = cr; data_wr = dw; data_rd = dr;
    @(negedge clk);
    ctrl_wr = 0; ctrl_rd = 0; data_wr = 0; data_rd = 0;
  endtask

  task automatic idle(input string req);
    step(0, 16'h0, 0, 0, 0, req);
  endtask

  initial begin
    ctrl_wr = 1; ctrl_wdata = 16'h4FFF;
    repeat (3) @(negedge clk);
    ctrl_wr = 0;
    rst = 0;
    #1;
    chk("R1", "pending", 32'(pending), 0);
    chk("R1", "vram_addr", 32'(vram_addr), 0);
    chk("R1", "access_code", 32'(access_code), 0);
    chk("R1", "strobes", {29'd0, reg_stb, dma_start, rdflag_clr}, 0);
    @(negedge clk);

    // register writes, boundary indices in both modes
    step(1, 16'h9755, 0, 0, 0, "R3");   // idx 23, mode5
    step(1, 16'h9866, 0, 0, 0, "R4");   // idx 24 rejected
    mode5 = 0;
    step(1, 16'h8A12, 0, 0, 0, "R4");   // idx 10 accepted
    step(1, 16'h8B34, 0, 0, 0, "R4");   // idx 11 rejected
    mode5 = 1;
    // two-word sequence with DMA enabled, code5 set
    step(1, 16'h4123, 0, 0, 0, "R5");
    idle("R5");
    step(1, 16'h0083, 0, 0, 0, "R6");
    idle("R9");
    // DMA disabled, second word without bit 7: code5 must stay
    dma_enable = 0;
    step(1, 16'h0456, 0, 0, 0, "R11");
    step(1, 16'h0014, 0, 0, 0, "R7");
    // DMA enabled, clear code5
    dma_enable = 1;
    step(1, 16'h0456, 0, 0, 0, "R11");
    step(1, 16'h0011, 0, 0, 0, "R9");
    // ignored while DMA runs
    dma_busy = 1;
    step(1, 16'h4777, 0, 0, 0, "R2");
    step(1, 16'h9102, 0, 0, 0, "R2");
    dma_busy = 0;
    // data write clears pending
    step(1, 16'hC321, 0, 0, 0, "R5");
    step(0, 16'h0, 0, 1, 0, "R8");
    // data read clears pending
    step(1, 16'h0222, 0, 0, 0, "R5");
    step(0, 16'h0, 0, 0, 1, "R8");
    // control read clears pending, status word
    fifo_empty = 0; open_bus = 16'h5C00; stat_lo = 9'h0AA;
    step(1, 16'h7FFF, 0, 0, 0, "R5");
    step(0, 16'h0, 1, 0, 0, "R8");
    fifo_empty = 1;
    step(0, 16'h0, 1, 0, 0, "R10");
    // data access while not pending has no effect
    step(0, 16'h0, 0, 1, 0, "R8");
    idle("R8");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule